// File: doc/BRIEF.md
# Shadow-Capture Path Delay Characteriser

This block measures how long one register-to-register combinational path takes to settle. The path output feeds two registers: a destination register on the system clock, and a shadow register clocked by a second clock at the same frequency whose edge falls a selectable number of phase steps after the launching system-clock edge. The shadow value is moved into the system-clock domain, and the two captures are compared in every cycle. When the shadow edge comes before the path has settled, the shadow holds the previous value and the comparison fails. The delay is therefore known to within one phase step.

A sweep controller drives a phase code to an external clock shifter. Phase code k places the shadow edge (k+1) steps after the launch edge. The sweep starts at the largest code and works downward. At each code it first waits a settling interval and then watches the comparator for a fixed window. The result is the first code at which the comparator reports a mismatch on N back-to-back cycles. If the sweep ends without such a code, the result is a saturated no-fail code. A result at or above a programmable threshold code marks the path as suspect, because its delay has grown past the limit that process spread allows.

A separate counter, clocked by a free-running ring-oscillator input, counts oscillator edges over a fixed window of system clocks. This gives a temperature proxy. The count is passed into the system-clock domain with a toggle handshake, and the value present at completion is attached to each delay result.

Top module: `pathdelay_char`

## Requirements
- R1: After reset, done_o is 0, phase_o is 0, step_o holds the no-fail code (all ones, 15 for 8 steps), suspect_o is 0, and temp_o and step_temp_o are 0.
- R2: A start captured while idle sets phase_o to NSTEPS-1 on the next edge. phase_o then drops by one every SETTLE_CYC+WATCH_CYC cycles (20 by default) and never rises during a sweep.
- R3: The destination and shadow captures of the same launch are compared once per system cycle. A mismatch counts only while it repeats on consecutive cycles, and a matching cycle clears the run.
- R4: The reported step is the highest phase code whose watch window contains nreq_i consecutive mismatches. An nreq_i of 0 is treated as 1.
- R5: When no code meets R4, step_o takes the no-fail code 2^SW-1 (15 by default). A sweep that never fails finishes 8*20 = 160 cycles after the start edge.
- R6: suspect_o is 1 exactly when step_o is not the no-fail code and step_o >= thresh_i.
- R7: done_o is a one-cycle pulse. step_o, suspect_o and step_temp_o change only with that pulse and hold until the next one.
- R8: temp_o is the number of osc_i rising edges counted over a window of WIN_CLKS (1024) system clocks, carried across by a toggle handshake.
- R9: step_temp_o is the temperature count present when the sweep finished.
- R10: A start pulse during a sweep is ignored. phase_o keeps descending and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| shclk_i | input | 1 | Phase-shifted shadow clock from the external shifter |
| osc_i | input | 1 | Free-running ring-oscillator clock |
| path_i | input | DW | Output of the combinational path under test |
| start_i | input | 1 | Starts a sweep when idle |
| nreq_i | input | CW | Consecutive mismatches needed to confirm a step |
| thresh_i | input | SW | Suspect threshold code |
| phase_o | output | SW | Phase code to the clock shifter |
| done_o | output | 1 | One-cycle completion pulse |
| step_o | output | SW | Delay signature, or the no-fail code |
| suspect_o | output | 1 | Delay at or above the threshold |
| step_temp_o | output | TW | Temperature count attached to the result |
| temp_o | output | TW | Latest temperature count |

## Verification
The sweep controller can see a new start request in the same cycle that it closes a watch window and lowers the phase code. The bench provokes this by pulsing start so that it is captured on the 60th edge of a sweep, which is exactly the end of the third step. It judges the outcome in two ways: phase_o right after that edge must read 4 and not jump back to 7, and the final step and suspect flag must match the values the bench derives from the modelled path delay.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WATCH  = 2'd2
    } sweep_st_e;
endpackage

// File: rtl/pdc_capture.sv
module pdc_capture #(
    parameter int DW = 8
) (
    input  logic          clk_i,
    input  logic          shclk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] path_i,
    output logic          mismatch_o
);
    typedef struct packed {
        logic [DW-1:0] dest;
        logic [DW-1:0] shrt;
    } cap_t;

    cap_t          cap_d, cap_q;
    logic [DW-1:0] shadow_q;

    // shadow register: same input as the destination, clocked by the shifted clock
    always_ff @(posedge shclk_i or negedge rst_ni) begin
        if (!rst_ni) shadow_q <= '0;
        else         shadow_q <= path_i;
    end

    always_comb begin
        cap_d      = cap_q;
        cap_d.dest = path_i;
        cap_d.shrt = shadow_q;   // retime the shadow sample of the same launch
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign mismatch_o = (cap_q.dest != cap_q.shrt);
endmodule

// File: rtl/pdc_tempmeter.sv
module pdc_tempmeter #(
    parameter int TW       = 16,
    parameter int WIN_CLKS = 1024
) (
    input  logic          clk_i,
    input  logic          osc_i,
    input  logic          rst_ni,
    output logic [TW-1:0] temp_o
);
    localparam int WW = (WIN_CLKS > 2) ? $clog2(WIN_CLKS) : 1;

    typedef struct packed {
        logic [WW-1:0] wcnt;
        logic          req;
        logic          ack_s1;
        logic          ack_s2;
        logic          ack_prev;
        logic [TW-1:0] temp;
    } sys_t;

    typedef struct packed {
        logic          req_s1;
        logic          req_s2;
        logic          req_prev;
        logic [TW-1:0] cnt;
        logic [TW-1:0] hold;
        logic          ack;
    } osc_t;

    sys_t sys_d, sys_q;
    osc_t osc_d, osc_q;

    // system-clock side: window timer, request toggle, result pickup
    always_comb begin
        sys_d        = sys_q;
        sys_d.ack_s1 = osc_q.ack;
        sys_d.ack_s2 = sys_q.ack_s1;
        if (sys_q.wcnt == WW'(WIN_CLKS - 1)) begin
            sys_d.wcnt = '0;
            sys_d.req  = ~sys_q.req;
        end else begin
            sys_d.wcnt = sys_q.wcnt + 1'b1;
        end
        if (sys_q.ack_s2 != sys_q.ack_prev) begin
            sys_d.temp     = osc_q.hold;
            sys_d.ack_prev = sys_q.ack_s2;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sys_q <= '0;
        else         sys_q <= sys_d;
    end

    // oscillator side: edge counter, snapshot on request, acknowledge toggle
    always_comb begin
        osc_d        = osc_q;
        osc_d.req_s1 = sys_q.req;
        osc_d.req_s2 = osc_q.req_s1;
        if (osc_q.req_s2 != osc_q.req_prev) begin
            osc_d.req_prev = osc_q.req_s2;
            osc_d.hold     = osc_q.cnt;
            osc_d.cnt      = TW'(1);
            osc_d.ack      = ~osc_q.ack;
        end else if (osc_q.cnt != {TW{1'b1}}) begin
            osc_d.cnt = osc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge osc_i or negedge rst_ni) begin
        if (!rst_ni) osc_q <= '0;
        else         osc_q <= osc_d;
    end

    assign temp_o = sys_q.temp;

    // R8: at most one request toggle per window
    a_r8_one_req_per_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sys_q.req) |=> $stable(sys_q.req));

    // R8: a reading is only taken up on an acknowledge edge
    a_r8_temp_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sys_q.ack_s2 == sys_q.ack_prev) |=> $stable(sys_q.temp));
endmodule

// File: rtl/pdc_sweep.sv
module pdc_sweep
    import pdc_pkg::*;
#(
    parameter int NSTEPS     = 8,
    parameter int SW         = 4,
    parameter int CW         = 4,
    parameter int TW         = 16,
    parameter int SETTLE_CYC = 4,
    parameter int WATCH_CYC  = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          start_i,
    input  logic [CW-1:0] nreq_i,
    input  logic [SW-1:0] thresh_i,
    input  logic          mismatch_i,
    input  logic [TW-1:0] temp_i,
    output logic [SW-1:0] phase_o,
    output logic          done_o,
    output logic [SW-1:0] step_o,
    output logic          suspect_o,
    output logic [TW-1:0] step_temp_o
);
    localparam int            TMAX   = (SETTLE_CYC > WATCH_CYC) ? SETTLE_CYC : WATCH_CYC;
    localparam int            TMW    = (TMAX > 2) ? $clog2(TMAX) : 1;
    localparam logic [SW-1:0] NOFAIL = {SW{1'b1}};
    localparam logic [SW-1:0] TOP    = SW'(NSTEPS - 1);

    typedef struct packed {
        sweep_st_e      st;
        logic [SW-1:0]  phase;
        logic [TMW-1:0] tmr;
        logic [CW-1:0]  run;
        logic [SW-1:0]  step;
        logic           susp;
        logic [TW-1:0]  tmp;
        logic           done;
    } sw_t;

    sw_t           q, d;
    logic [CW-1:0] nreq_eff;
    logic [CW-1:0] run_inc;
    logic          confirm;
    logic          win_end;
    logic          settle_end;

    always_comb begin
        nreq_eff   = (nreq_i == '0) ? CW'(1) : nreq_i;
        run_inc    = !mismatch_i ? '0 :
                     ((q.run == {CW{1'b1}}) ? q.run : q.run + 1'b1);
        confirm    = mismatch_i && (run_inc >= nreq_eff);
        win_end    = (q.tmr == TMW'(WATCH_CYC - 1));
        settle_end = (q.tmr == TMW'(SETTLE_CYC - 1));

        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st    = ST_SETTLE;
                    d.phase = TOP;
                    d.tmr   = '0;
                    d.run   = '0;
                end
            end
            ST_SETTLE: begin
                if (settle_end) begin
                    d.st  = ST_WATCH;
                    d.tmr = '0;
                    d.run = '0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_WATCH: begin
                d.run = run_inc;
                if (confirm) begin
                    d.st   = ST_IDLE;
                    d.step = q.phase;
                    d.susp = (q.phase >= thresh_i);
                    d.tmp  = temp_i;
                    d.done = 1'b1;
                end else if (win_end) begin
                    if (q.phase == '0) begin
                        d.st   = ST_IDLE;
                        d.step = NOFAIL;
                        d.susp = 1'b0;
                        d.tmp  = temp_i;
                        d.done = 1'b1;
                    end else begin
                        d.st    = ST_SETTLE;
                        d.phase = q.phase - 1'b1;
                        d.tmr   = '0;
                    end
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.step  <= NOFAIL;
        end else begin
            q <= d;
        end
    end

    assign phase_o     = q.phase;
    assign done_o      = q.done;
    assign step_o      = q.step;
    assign suspect_o   = q.susp;
    assign step_temp_o = q.tmp;

    // R7: completion is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7: the result only moves together with done
    a_r7_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(step_o) |-> done_o);

    // R2, R10: the phase code never climbs during a sweep
    a_r2_phase_descends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st != ST_IDLE) |=> (phase_o <= $past(phase_o)));

    // R2: the phase code stays inside the step range
    a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o <= TOP);

    // R6: the no-fail code is never suspect
    a_r6_nofail_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_o == NOFAIL) |-> !suspect_o);
endmodule

// File: rtl/pathdelay_char.sv
module pathdelay_char #(
    parameter int DW         = 8,
    parameter int NSTEPS     = 8,
    parameter int CW         = 4,
    parameter int TW         = 16,
    parameter int SETTLE_CYC = 4,
    parameter int WATCH_CYC  = 16,
    parameter int WIN_CLKS   = 1024
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          shclk_i,
    input  logic                          osc_i,
    input  logic [DW-1:0]                 path_i,
    input  logic                          start_i,
    input  logic [CW-1:0]                 nreq_i,
    input  logic [$clog2(NSTEPS+1)-1:0]   thresh_i,
    output logic [$clog2(NSTEPS+1)-1:0]   phase_o,
    output logic                          done_o,
    output logic [$clog2(NSTEPS+1)-1:0]   step_o,
    output logic                          suspect_o,
    output logic [TW-1:0]                 step_temp_o,
    output logic [TW-1:0]                 temp_o
);
    localparam int SW = $clog2(NSTEPS + 1);

    logic          mismatch;
    logic [TW-1:0] temp;

    pdc_capture #(.DW(DW)) u_capture (
        .clk_i      (clk_i),
        .shclk_i    (shclk_i),
        .rst_ni     (rst_ni),
        .path_i     (path_i),
        .mismatch_o (mismatch)
    );

    pdc_tempmeter #(.TW(TW), .WIN_CLKS(WIN_CLKS)) u_tempmeter (
        .clk_i  (clk_i),
        .osc_i  (osc_i),
        .rst_ni (rst_ni),
        .temp_o (temp)
    );

    pdc_sweep #(
        .NSTEPS     (NSTEPS),
        .SW         (SW),
        .CW         (CW),
        .TW         (TW),
        .SETTLE_CYC (SETTLE_CYC),
        .WATCH_CYC  (WATCH_CYC)
    ) u_sweep (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .nreq_i      (nreq_i),
        .thresh_i    (thresh_i),
        .mismatch_i  (mismatch),
        .temp_i      (temp),
        .phase_o     (phase_o),
        .done_o      (done_o),
        .step_o      (step_o),
        .suspect_o   (suspect_o),
        .step_temp_o (step_temp_o)
    );

    assign temp_o = temp;
endmodule

// File: tb/pathdelay_char_bench.sv
`timescale 1ns/1ps
module pathdelay_char_bench;
    localparam int NOFAIL = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shclk = 1'b0;
    logic       osc = 1'b0;
    logic [7:0] src = 8'd0;
    logic [7:0] path_w = 8'd0;
    logic       start = 1'b0;
    logic [3:0] nreq = 4'd1;
    logic [3:0] thresh = 4'd4;
    logic [3:0] phase;
    logic       done;
    logic [3:0] step;
    logic       suspect;
    logic [15:0] step_temp;
    logic [15:0] temp;

    realtime dly = 0.2;
    realtime osc_half = 5.0;
    bit      alt = 1'b0;
    bit      tick = 1'b0;
    int      total = 0;
    int      bad = 0;
    int      t_lo = 405;
    int      t_hi = 414;

    pathdelay_char u_pathdelay_char (
        .clk_i(clk), .rst_ni(rst_n), .shclk_i(shclk), .osc_i(osc),
        .path_i(path_w), .start_i(start), .nreq_i(nreq), .thresh_i(thresh),
        .phase_o(phase), .done_o(done), .step_o(step), .suspect_o(suspect),
        .step_temp_o(step_temp), .temp_o(temp)
    );

    always #2 clk = ~clk;
    always #(osc_half) osc = ~osc;

    // external shifter model: code k puts the shadow edge (k+1)*0.4 ns after launch
    always begin
        @(posedge clk);
        #((real'(phase) + 1.0) * 0.4);
        shclk = 1'b1;
        #0.3;
        shclk = 1'b0;
    end

    // launch register and delayed path
    always @(posedge clk) begin
        tick <= ~tick;
        if (!alt || tick) src <= src + 8'd1;
    end
    always @(src) path_w <= #(dly) src;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_step(input int dps, input bit a, input int n);
        int ne = (n == 0) ? 1 : n;
        if (a && ne > 1) return NOFAIL;
        for (int k = 7; k >= 0; k--)
            if ((k + 1) * 400 < dps) return k;
        return NOFAIL;
    endfunction

    task automatic run(input int n, input int thr, input bit trace, input bit poke,
                       output int cyc);
        @(negedge clk);
        nreq = 4'(n); thresh = 4'(thr); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        if (trace) chk(phase == 4'd7, "R2", "phase after start", phase, 7);
        while (!done && cyc < 2000) begin
            if (poke && cyc == 59) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (trace && cyc < 160 && (cyc % 20) == 10)
                chk(phase == 4'(7 - cyc / 20), "R2", "phase during sweep", phase, 7 - cyc / 20);
            if (poke && cyc == 60)
                chk(phase == 4'd4, "R10", "phase after ignored start", phase, 4);
        end
        chk(cyc < 2000, "R7", "done arrived", cyc, 0);
    endtask

    task automatic one_case(input int dps, input bit a, input int n, input int thr,
                            input bit trace, input bit poke);
        int cyc;
        int es;
        logic [3:0] held;
        dly = real'(dps) / 1000.0;
        alt = a;
        es  = exp_step(dps, a, n);
        repeat (8) @(negedge clk);
        run(n, thr, trace, poke, cyc);
        chk(step == 4'(es), (n == 0) ? "R4" : (es == NOFAIL ? "R5" : "R4"),
            $sformatf("step dly=%0dps alt=%0d n=%0d", dps, a, n), step, es);
        chk(suspect == (es != NOFAIL && es >= thr), "R6",
            $sformatf("suspect thr=%0d", thr), suspect, (es != NOFAIL && es >= thr));
        chk(step_temp >= 16'(t_lo) && step_temp <= 16'(t_hi), "R9",
            "attached temperature", step_temp, t_lo);
        if (trace) chk(cyc == 160, "R5", "no-fail sweep length", cyc, 160);
        held = step;
        @(negedge clk);
        chk(!done, "R7", "done pulse width", done, 0);
        chk(step == held, "R7", "result held", step, held);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done, "R1", "done after reset", done, 0);
        chk(phase == 4'd0, "R1", "phase after reset", phase, 0);
        chk(step == 4'(NOFAIL), "R1", "step after reset", step, NOFAIL);
        chk(!suspect, "R1", "suspect after reset", suspect, 0);
        chk(temp == 16'd0 && step_temp == 16'd0, "R1", "temp after reset", temp, 0);

        repeat (2600) @(negedge clk);
        chk(temp >= 16'(t_lo) && temp <= 16'(t_hi), "R8", "temp count 10ns osc", temp, 410);

        // R3/R4/R5: every delay bin, continuous launches
        for (int i = 0; i < 9; i++)
            one_case(200 + 400 * i, 1'b0, 2, 4, i == 0, i == 5);

        // R3/R4: intermittent mismatches against the confirm count
        one_case(2200, 1'b1, 1, 4, 1'b0, 1'b0);
        one_case(2200, 1'b1, 2, 4, 1'b0, 1'b0);
        one_case(2200, 1'b1, 0, 4, 1'b0, 1'b0);

        // R6: threshold sweep over every code
        for (int t = 0; t < 9; t++)
            one_case(2200, 1'b0, 1, t, 1'b0, 1'b0);

        // R8: faster oscillator
        osc_half = 3.5;
        t_lo = 581; t_hi = 590;
        repeat (2600) @(negedge clk);
        chk(temp >= 16'(t_lo) && temp <= 16'(t_hi), "R8", "temp count 7ns osc", temp, 585);
        one_case(1400, 1'b0, 3, 2, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule